// File: doc/BRIEF.md
# Paced Serial Transmitter with Finish Flag

This block sends 8-bit words as asynchronous serial frames: one start bit (low), eight data bits least significant first, and one stop bit (high). Software or a bus master drops a word into a one-entry holding register. The word moves into a shift register as soon as the shift register is idle and the transmitter is allowed to go. Each bit stays on the line until the next pulse of an external bit-rate tick.

Transmission can be paced in two ways. The first is a clear-to-send input, which is checked only when automatic pacing is enabled. The second is a software pause control. Neither one stops a frame that has already started. They hold back only the handover from the holding register to the shift register. A polarity control picks whether clear-to-send is active low (the default) or active high.

The block has two sticky status bits, each with its own interrupt request:
- The finish flag marks the moment the holding and shift registers have both drained, which is the point where the line driver may be switched off.
- The sticky clear-to-send flag records that the clear-to-send input was active.

Top module: `uart_txc_top`

## Requirements
- R1: Each frame on `tx_out` is a start bit of 0, then data bits 0 through 7, then a stop bit of 1. The start bit is driven in the cycle after the word loads. Every bit ends on a `baud_tick` pulse. The line idles at 1.
- R2: `hold_empty` falls in the cycle after an accepted write and rises in the cycle after the word moves to the shift register. A write while `hold_empty` is 0 is ignored.
- R3: With `auto_cts_en`=1 and clear-to-send inactive, a frame already being shifted completes. The held word stays in the holding register until clear-to-send becomes active again.
- R4: While `tx_pause`=1, the held word is not moved to the shift register, whatever the state of clear-to-send. A frame in progress still completes.
- R5: With `auto_cts_en`=0, `cts_pin` has no effect on transmission.
- R6: `cts_stat` is 1 when the pin value, after two synchronizing flops, is active. Active is low when `hs_pol`=0 and high when `hs_pol`=1.
- R7: `cts_sticky` is set in the cycle after `cts_stat` is 1. It is cleared only by a `clr_cts_sticky` pulse while clear-to-send is inactive. `modem_req` = `cts_sticky` AND `modem_irq_en`.
- R8: `tx_empty` is 1 exactly when the holding and shift registers are both empty.
- R9: `fin_flag` sets one cycle after `tx_empty` rises. It holds until a `clr_fin` pulse, and a new rise of `tx_empty` takes priority over a clear in the same cycle. `fin_req` = `fin_flag` AND `fin_irq_en`.
- R10: During and right after reset, `tx_out`=1, `hold_empty`=1, `tx_empty`=1, `fin_flag`=0 and `cts_sticky`=0. Reset asserts asynchronously and releases two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Word to send |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| cts_pin | input | 1 | Clear-to-send input, asynchronous |
| auto_cts_en | input | 1 | Enables pacing by clear-to-send |
| hs_pol | input | 1 | 0: handshake active low, 1: active high |
| tx_pause | input | 1 | Software pause of the holding-to-shift handover |
| fin_irq_en | input | 1 | Enables `fin_req` |
| modem_irq_en | input | 1 | Enables `modem_req` |
| clr_fin | input | 1 | Write-one-to-clear pulse for `fin_flag` |
| clr_cts_sticky | input | 1 | Write-one-to-clear pulse for `cts_sticky` |
| tx_out | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register is empty |
| tx_empty | output | 1 | Holding and shift registers are both empty |
| fin_flag | output | 1 | Sticky transmit-finished flag |
| cts_stat | output | 1 | Synchronized clear-to-send is active |
| cts_sticky | output | 1 | Sticky copy of `cts_stat` |
| fin_req | output | 1 | Finished interrupt request |
| modem_req | output | 1 | Modem-status interrupt request |

## Verification
A wrong bit index or bit counter in the shift register shows on `tx_out` within one bit time and shifts every later frame. A lost or early handover shows on `hold_empty` and `tx_empty` in the very next cycle. A pacing fault that lets the held word go while clear-to-send or the pause bit should block it shows as `hold_empty` rising, which the bench watches across a whole frame time of stalled input. Since the reference model is compared against every output on every clock, a fault in the synchronizer depth or in the sticky-flag set and clear priority is caught in the first cycle where the two differ.

// File: rtl/uart_txc_pkg.sv
`timescale 1ns/1ps
package uart_txc_pkg;
  parameter int unsigned DEF_DATA_W      = 8;
  parameter int unsigned DEF_SYNC_STAGES = 2;

  // level of a handshake pin translated to "active"
  function automatic logic hs_active(input logic lvl, input logic pol);
    return pol ? lvl : ~lvl;
  endfunction
endpackage

// File: rtl/txc_cts_mon.sv
`timescale 1ns/1ps
module txc_cts_mon
  import uart_txc_pkg::*;
#(
  parameter int unsigned STAGES = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_pin,
  input  logic hs_pol,
  input  logic clr_sticky,
  input  logic irq_en,
  output logic cts_act,
  output logic sticky,
  output logic req
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              sticky_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign sync_d[0] = cts_pin;
    end else begin : g_next
      assign sync_d[i] = sync_q[i-1];
    end
  end

  always_comb begin
    cts_act  = hs_active(sync_q[STAGES-1], hs_pol);
    sticky_d = cts_act | (sticky & ~clr_sticky);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      sticky <= 1'b0;
    end else begin
      sync_q <= sync_d;
      sticky <= sticky_d;
    end
  end

  assign req = sticky & irq_en;

  a_r7_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky && !clr_sticky) |=> sticky);
  a_r7_sets_on_active: assert property (@(posedge clk) disable iff (!rst_n)
    cts_act |=> sticky);
endmodule

// File: rtl/txc_holding.sv
`timescale 1ns/1ps
module txc_holding #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              valid,
  output logic [DATA_W-1:0] data
);
  logic              valid_d;
  logic              data_en;

  always_comb begin
    valid_d = valid;
    data_en = 1'b0;
    if (take) begin
      valid_d = 1'b0;
    end else if (wr_en && !valid) begin
      valid_d = 1'b1;
      data_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data <= '0;
    else if (data_en) data <= wr_data;
  end

  a_r2_write_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !take) |=> (valid && $stable(data)));
endmodule

// File: rtl/txc_shifter.sv
`timescale 1ns/1ps
module txc_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              baud_tick,
  output logic              busy,
  output logic              tx
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               busy_d;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    busy_d = busy;
    if (busy && baud_tick) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
        sh_d  = {1'b1, sh_q[FRAME_W-1:1]};
      end
    end else if (!busy && load) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      sh_d   = {1'b1, load_data, 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      cnt_q <= '0;
      busy  <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      busy  <= busy_d;
    end
  end

  assign tx = busy ? sh_q[0] : 1'b1;

  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx);
  a_r1_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q == LAST) |-> tx);
  a_r1_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick) |=> (busy && $stable(tx)));
endmodule

// File: rtl/uart_txc_top.sv
`timescale 1ns/1ps
module uart_txc_top
  import uart_txc_pkg::*;
#(
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              baud_tick,
  input  logic              cts_pin,
  input  logic              auto_cts_en,
  input  logic              hs_pol,
  input  logic              tx_pause,
  input  logic              fin_irq_en,
  input  logic              modem_irq_en,
  input  logic              clr_fin,
  input  logic              clr_cts_sticky,
  output logic              tx_out,
  output logic              hold_empty,
  output logic              tx_empty,
  output logic              fin_flag,
  output logic              cts_stat,
  output logic              cts_sticky,
  output logic              fin_req,
  output logic              modem_req
);
  logic [1:0]        rst_sync_q;
  logic              rst_s;
  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic              busy;
  logic              may_go;
  logic              take;
  logic              empty_prev;
  logic              fin_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  txc_cts_mon #(.STAGES(SYNC_STAGES)) u_cts (
    .clk        (clk),
    .rst_n      (rst_s),
    .cts_pin    (cts_pin),
    .hs_pol     (hs_pol),
    .clr_sticky (clr_cts_sticky),
    .irq_en     (modem_irq_en),
    .cts_act    (cts_stat),
    .sticky     (cts_sticky),
    .req        (modem_req)
  );

  always_comb begin
    may_go = !tx_pause && (!auto_cts_en || cts_stat);
    take   = hold_valid && !busy && may_go;
  end

  txc_holding #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_s),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (take),
    .valid   (hold_valid),
    .data    (hold_data)
  );

  txc_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_s),
    .load      (take),
    .load_data (hold_data),
    .baud_tick (baud_tick),
    .busy      (busy),
    .tx        (tx_out)
  );

  assign hold_empty = !hold_valid;
  assign tx_empty   = !hold_valid && !busy;

  // sticky finished flag: rising edge of tx_empty wins over a clear
  always_comb begin
    fin_d = (tx_empty && !empty_prev) | (fin_flag & ~clr_fin);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      empty_prev <= 1'b1;
      fin_flag   <= 1'b0;
    end else begin
      empty_prev <= tx_empty;
      fin_flag   <= fin_d;
    end
  end

  assign fin_req = fin_flag & fin_irq_en;

  a_r3_cts_blocks: assert property (@(posedge clk) disable iff (!rst_s)
    (!hold_empty && auto_cts_en && !cts_stat) |=> !hold_empty);
  a_r4_pause_blocks: assert property (@(posedge clk) disable iff (!rst_s)
    (!hold_empty && tx_pause) |=> !hold_empty);
  a_r8_empty_implies_hold: assert property (@(posedge clk) disable iff (!rst_s)
    tx_empty |-> hold_empty);
  a_r9_fin_sticky: assert property (@(posedge clk) disable iff (!rst_s)
    (fin_flag && !clr_fin) |=> fin_flag);
  a_r9_fin_sets: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(tx_empty) |=> fin_flag);
endmodule

// File: tb/uart_txc_top_test.sv
`timescale 1ns/1ps
module uart_txc_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, baud_tick, cts_pin, auto_cts_en, hs_pol, tx_pause;
  logic       fin_irq_en, modem_irq_en, clr_fin, clr_cts_sticky;
  logic [7:0] wr_data;
  logic       tx_out, hold_empty, tx_empty, fin_flag, cts_stat, cts_sticky;
  logic       fin_req, modem_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  uart_txc_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .baud_tick(baud_tick), .cts_pin(cts_pin), .auto_cts_en(auto_cts_en),
    .hs_pol(hs_pol), .tx_pause(tx_pause), .fin_irq_en(fin_irq_en),
    .modem_irq_en(modem_irq_en), .clr_fin(clr_fin),
    .clr_cts_sticky(clr_cts_sticky), .tx_out(tx_out),
    .hold_empty(hold_empty), .tx_empty(tx_empty), .fin_flag(fin_flag),
    .cts_stat(cts_stat), .cts_sticky(cts_sticky), .fin_req(fin_req),
    .modem_req(modem_req)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, got, exp);
    end
  endtask

  // behavioural reference model
  int rcnt = 0;
  int m_s1, m_s2, m_hv, m_hd, m_busy, m_frame, m_idx, m_fin, m_prev, m_scts;

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_hv = 0; m_hd = 0; m_busy = 0; m_frame = 0;
    m_idx = 0; m_fin = 0; m_prev = 1; m_scts = 0;
  endtask

  function automatic int act_of(int s2, logic pol);
    return pol ? s2 : (s2 == 0 ? 1 : 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rcnt = 0; model_reset();
    end else if (rcnt < 2) begin
      rcnt++; model_reset();
    end else begin
      int act, go, take, empty_cur, n_fin, n_scts;
      act       = act_of(m_s2, hs_pol);
      go        = (!tx_pause && (!auto_cts_en || act != 0)) ? 1 : 0;
      take      = (m_hv != 0 && m_busy == 0 && go != 0) ? 1 : 0;
      empty_cur = (m_hv == 0 && m_busy == 0) ? 1 : 0;
      n_fin     = ((empty_cur != 0 && m_prev == 0) || (m_fin != 0 && !clr_fin)) ? 1 : 0;
      n_scts    = (act != 0 || (m_scts != 0 && !clr_cts_sticky)) ? 1 : 0;
      if (m_busy != 0 && baud_tick) begin
        if (m_idx == 9) m_busy = 0;
        else m_idx++;
      end else if (take != 0) begin
        m_busy = 1; m_idx = 0; m_frame = (1 << 9) | (m_hd << 1);
      end
      if (take != 0) m_hv = 0;
      else if (wr_en && m_hv == 0) begin m_hv = 1; m_hd = int'(wr_data); end
      m_prev = empty_cur; m_fin = n_fin; m_scts = n_scts;
      m_s2 = m_s1; m_s1 = int'(cts_pin);
    end
    #1;
    begin
      logic e_tx;
      e_tx = (m_busy != 0) ? logic'((m_frame >> m_idx) & 1) : 1'b1;
      check(tx_out, e_tx, "R1 tx_out");
      check(hold_empty, logic'(m_hv == 0), "R2 hold_empty");
      check(tx_empty, logic'(m_hv == 0 && m_busy == 0), "R8 tx_empty");
      check(fin_flag, logic'(m_fin != 0), "R9 fin_flag");
      check(fin_req, logic'(m_fin != 0 && fin_irq_en), "R9 fin_req");
      check(cts_stat, logic'(act_of(m_s2, hs_pol) != 0), "R6 cts_stat");
      check(cts_sticky, logic'(m_scts != 0), "R7 cts_sticky");
      check(modem_req, logic'(m_scts != 0 && modem_irq_en), "R7 modem_req");
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // bit-rate tick: one pulse every five cycles
  initial begin
    baud_tick = 1'b0;
    forever begin
      wait_cyc(4); baud_tick = 1'b1;
      wait_cyc(1); baud_tick = 1'b0;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; cts_pin = 1'b0;
    auto_cts_en = 1'b1; hs_pol = 1'b0; tx_pause = 1'b0;
    fin_irq_en = 1'b0; modem_irq_en = 1'b0; clr_fin = 1'b0; clr_cts_sticky = 1'b0;
    wait_cyc(3);
    check(tx_out, 1'b1, "R10 reset tx_out");
    check(hold_empty, 1'b1, "R10 reset hold_empty");
    check(tx_empty, 1'b1, "R10 reset tx_empty");
    check(fin_flag, 1'b0, "R10 reset fin_flag");
    check(cts_sticky, 1'b0, "R10 reset cts_sticky");
    rst_n = 1'b1;
    wait_cyc(3);
    fin_irq_en = 1'b1; modem_irq_en = 1'b1;

    // back-to-back words, third write while full is dropped (R2)
    put(8'hA5); wait_cyc(3);
    put(8'h3C); put(8'h77);
    wait_cyc(130);
    check(fin_flag, 1'b1, "R9 flag after drain");
    @(negedge clk); clr_fin = 1'b1; @(negedge clk); clr_fin = 1'b0;
    wait_cyc(1);
    check(fin_flag, 1'b0, "R9 cleared by write-one");

    // clear-to-send drops during a frame (R3)
    put(8'h11); wait_cyc(8);
    cts_pin = 1'b1;
    put(8'h22);
    wait_cyc(80);
    check(hold_empty, 1'b0, "R3 word held while inactive");
    check(tx_out, 1'b1, "R3 current frame completed");
    cts_pin = 1'b0;
    wait_cyc(70);
    check(tx_empty, 1'b1, "R3 released after active");

    // software pause (R4)
    tx_pause = 1'b1;
    put(8'h5A);
    wait_cyc(80);
    check(hold_empty, 1'b0, "R4 pause holds word");
    tx_pause = 1'b0;
    wait_cyc(70);
    check(tx_empty, 1'b1, "R4 sent after pause");

    // pin ignored when automatic pacing is off (R5)
    auto_cts_en = 1'b0; cts_pin = 1'b1;
    put(8'hC3);
    wait_cyc(70);
    check(tx_empty, 1'b1, "R5 sent with pin inactive");

    // sticky flag clear while inactive, set again when active (R7)
    @(negedge clk); clr_cts_sticky = 1'b1; @(negedge clk); clr_cts_sticky = 1'b0;
    wait_cyc(2);
    check(cts_sticky, 1'b0, "R7 sticky cleared");
    check(modem_req, 1'b0, "R7 request dropped");
    cts_pin = 1'b0;
    wait_cyc(5);
    check(cts_sticky, 1'b1, "R7 sticky set on active");

    // active-high polarity (R6)
    hs_pol = 1'b1; auto_cts_en = 1'b1; cts_pin = 1'b1;
    wait_cyc(4);
    check(cts_stat, 1'b1, "R6 high is active");
    put(8'h96);
    wait_cyc(70);
    check(tx_empty, 1'b1, "R6 sent with high pin");
    cts_pin = 1'b0;
    wait_cyc(4);
    put(8'h69);
    wait_cyc(70);
    check(hold_empty, 1'b0, "R6 low pin blocks");
    cts_pin = 1'b1;
    wait_cyc(70);
    check(tx_empty, 1'b1, "R6 resumes");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule